// File: doc/BRIEF.md
# Processor Status Word Flags Unit

This block holds the 16-bit status word of a small processor core. Six condition flags are derived from the operands, result and carry-out that the ALU reports for each byte-wide or word-wide add, subtract or logic operation. Three control flags are managed separately. They are trace (single-step), interrupt enable and string direction. They change on explicit set/clear commands, on interrupt acceptance, on interrupt return and on reset.

The core drives one operation class per cycle, together with a size select and any control commands. The updated word appears on the output after the next rising clock edge. A full word write lets software load every implemented bit, including the trace flag, which has no command of its own. The interrupt return path takes the word popped from the stack and restores the trace and enable bits from it. The ALU, the stack memory and the interrupt controller sit outside this block.

Top module: `psw_unit`

## Requirements
- R1: Bit layout of `psw_o`: carry=0, parity=2, aux-carry=4, zero=6, sign=7, trace=8, int-enable=9, direction=10, overflow=11. The seven other bits always read 0, even after a full word write of all ones.
- R2: While `rst_ni` is low, `psw_o` is 16'h0000. This leaves interrupts disabled.
- R3: `op_cls_i` codes are 0 none, 1 add, 2 subtract, 3 logic. `word_i`=1 selects 16-bit and 0 selects 8-bit. Condition flags change on the edge after a non-zero class. With class 0 they hold.
- R4: Carry equals `alu_co_i` for add and subtract, where the input is the carry-out or borrow of the selected width. Logic operations clear carry.
- R5: Parity is 1 when bits 7:0 of `alu_res_i` hold an even number of ones, at either size.
- R6: Aux-carry is bit 4 of `opa_i ^ opb_i ^ alu_res_i` for add and subtract, which is the carry or borrow across bit 3. Logic operations clear it.
- R7: Zero is 1 when the result is zero over the selected width only. Sign copies bit 7 (byte) or bit 15 (word) of the result.
- R8: Overflow is set for add when both operands share a sign bit and the result's differs, and for subtract (a-b) when the operand signs differ and the result's sign differs from a. Logic operations clear it.
- R9: `irq_take_i` clears trace and int-enable. `irq_ret_i` loads them from bits 8 and 9 of `pop_word_i` and wins over `irq_take_i`. Neither touches other flags.
- R10: `ie_set_i`/`ie_clr_i` set and clear int-enable, and `dir_set_i`/`dir_clr_i` do the same for direction. Clear wins over set. An interrupt take or return overrides the int-enable commands.
- R11: `wr_en_i` loads all nine flags from `wr_word_i` and overrides every other input in that cycle. Trace changes only through a word write, an interrupt take or an interrupt return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| opa_i | input | 16 | ALU operand A |
| opb_i | input | 16 | ALU operand B |
| alu_res_i | input | 16 | ALU result |
| alu_co_i | input | 1 | Carry-out / borrow of the selected width |
| op_cls_i | input | 2 | Operation class |
| word_i | input | 1 | 1 = 16-bit operation, 0 = 8-bit |
| ie_set_i | input | 1 | Set interrupt enable |
| ie_clr_i | input | 1 | Clear interrupt enable |
| dir_set_i | input | 1 | Set direction flag |
| dir_clr_i | input | 1 | Clear direction flag |
| irq_take_i | input | 1 | Interrupt accepted |
| irq_ret_i | input | 1 | Interrupt return |
| pop_word_i | input | 16 | Flag word popped on return |
| wr_en_i | input | 1 | Full word write |
| wr_word_i | input | 16 | Word to write |
| psw_o | output | 16 | Status word |

## Verification
Every result of this block lands exactly one clock edge after its stimulus, because each flag has a single register between input and output. The ALU condition flags, the command-driven control flags and full word writes all follow that rule. The bench changes inputs on a falling edge and samples `psw_o` on the following falling edge, after exactly one rising edge. It clears the commands at that same point, so no stimulus lasts longer than one edge. Hold cases use class 0 and check on that same single-edge spacing.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int PSW_W  = 16;
  localparam int BYTE_W = 8;

  localparam int C_POS = 0;
  localparam int P_POS = 2;
  localparam int A_POS = 4;
  localparam int Z_POS = 6;
  localparam int S_POS = 7;
  localparam int T_POS = 8;
  localparam int I_POS = 9;
  localparam int D_POS = 10;
  localparam int O_POS = 11;

  localparam logic [PSW_W-1:0] IMPL_MASK =
      PSW_W'((1 << C_POS) | (1 << P_POS) | (1 << A_POS) | (1 << Z_POS) |
             (1 << S_POS) | (1 << T_POS) | (1 << I_POS) | (1 << D_POS) |
             (1 << O_POS));

  typedef enum logic [1:0] {
    OPC_NONE  = 2'd0,
    OPC_ADD   = 2'd1,
    OPC_SUB   = 2'd2,
    OPC_LOGIC = 2'd3
  } op_cls_e;

  typedef struct packed {
    logic o;
    logic s;
    logic z;
    logic a;
    logic p;
    logic c;
  } cond_t;
endpackage

// File: rtl/psw_cond_calc.sv
module psw_cond_calc
  import psw_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8,
  parameter int NIB_BIT  = 4
) (
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic [DATA_W-1:0] res_i,
  input  logic              co_i,
  input  op_cls_e           op_i,
  input  logic              wide_i,
  output cond_t             cond_o,
  output logic              upd_o
);
  localparam int WIDE_MSB   = DATA_W - 1;
  localparam int NARROW_MSB = NARROW_W - 1;

  logic a_msb, b_msb, r_msb;
  logic is_arith, is_sub;
  logic zero_w, zero_n;
  logic [DATA_W-1:0] half_sum;

  assign a_msb    = wide_i ? opa_i[WIDE_MSB] : opa_i[NARROW_MSB];
  assign b_msb    = wide_i ? opb_i[WIDE_MSB] : opb_i[NARROW_MSB];
  assign r_msb    = wide_i ? res_i[WIDE_MSB] : res_i[NARROW_MSB];
  assign zero_w   = (res_i == '0);
  assign zero_n   = (res_i[NARROW_W-1:0] == '0);
  assign half_sum = opa_i ^ opb_i ^ res_i;
  assign is_arith = (op_i == OPC_ADD) || (op_i == OPC_SUB);
  assign is_sub   = (op_i == OPC_SUB);
  assign upd_o    = (op_i != OPC_NONE);

  always_comb begin
    cond_o   = '0;
    cond_o.z = wide_i ? zero_w : zero_n;
    cond_o.s = r_msb;
    cond_o.p = ~^res_i[NARROW_W-1:0];
    if (is_arith) begin
      cond_o.c = co_i;
      cond_o.a = half_sum[NIB_BIT];
      // subtract flips the sign condition on b
      cond_o.o = ((a_msb ^ b_msb) == is_sub) && (r_msb != a_msb);
    end
  end

  logic unused_calc;
  assign unused_calc = ^half_sum;
endmodule

// File: rtl/psw_cond_reg.sv
module psw_cond_reg
  import psw_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_en_i,
  input  cond_t wr_cond_i,
  input  logic  upd_i,
  input  cond_t calc_i,
  output cond_t cond_o
);
  cond_t cond_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cond_q <= '0;
    else if (wr_en_i) cond_q <= wr_cond_i;
    else if (upd_i)   cond_q <= calc_i;
  end

  assign cond_o = cond_q;

  AST_COND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && !upd_i) |=> $stable(cond_o)); // R3
  AST_COND_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (cond_o == $past(wr_cond_i))); // R11
endmodule

// File: rtl/psw_ctrl_flags.sv
module psw_ctrl_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_en_i,
  input  logic wr_tf_i,
  input  logic wr_if_i,
  input  logic wr_df_i,
  input  logic take_i,
  input  logic ret_i,
  input  logic pop_tf_i,
  input  logic pop_if_i,
  input  logic ie_set_i,
  input  logic ie_clr_i,
  input  logic dir_set_i,
  input  logic dir_clr_i,
  output logic tf_o,
  output logic if_o,
  output logic df_o
);
  logic tf_q, if_q, df_q;
  logic tf_d, if_d, df_d;

  always_comb begin
    tf_d = tf_q;
    if_d = if_q;
    df_d = df_q;
    if (wr_en_i) begin
      tf_d = wr_tf_i;
      if_d = wr_if_i;
      df_d = wr_df_i;
    end else begin
      if (ret_i) begin
        tf_d = pop_tf_i;
        if_d = pop_if_i;
      end else if (take_i) begin
        tf_d = 1'b0;
        if_d = 1'b0;
      end else if (ie_clr_i) begin
        if_d = 1'b0;
      end else if (ie_set_i) begin
        if_d = 1'b1;
      end
      if (dir_clr_i)      df_d = 1'b0;
      else if (dir_set_i) df_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tf_q <= 1'b0;
      if_q <= 1'b0;
      df_q <= 1'b0;
    end else begin
      tf_q <= tf_d;
      if_q <= if_d;
      df_q <= df_d;
    end
  end

  assign tf_o = tf_q;
  assign if_o = if_q;
  assign df_o = df_q;

  AST_TAKE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !ret_i && !wr_en_i) |=> (!tf_o && !if_o)); // R9
  AST_RET_RESTORES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && !wr_en_i) |=> (tf_o == $past(pop_tf_i) && if_o == $past(pop_if_i))); // R9
  AST_IE_CLR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ie_clr_i && !wr_en_i && !ret_i) |=> !if_o); // R10
  AST_DIR_CLR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_clr_i && !wr_en_i) |=> !df_o); // R10
  AST_TF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && !ret_i && !take_i) |=> $stable(tf_o)); // R11
endmodule

// File: rtl/psw_unit.sv
module psw_unit
  import psw_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [15:0] opa_i,
  input  logic [15:0] opb_i,
  input  logic [15:0] alu_res_i,
  input  logic        alu_co_i,
  input  logic [1:0]  op_cls_i,
  input  logic        word_i,
  input  logic        ie_set_i,
  input  logic        ie_clr_i,
  input  logic        dir_set_i,
  input  logic        dir_clr_i,
  input  logic        irq_take_i,
  input  logic        irq_ret_i,
  input  logic [15:0] pop_word_i,
  input  logic        wr_en_i,
  input  logic [15:0] wr_word_i,
  output logic [15:0] psw_o
);
  op_cls_e op_cls;
  cond_t   calc_cond, wr_cond, cond_q;
  logic    calc_upd;
  logic    tf, ie, df;

  assign op_cls = op_cls_e'(op_cls_i);

  psw_cond_calc #(
    .DATA_W  (PSW_W),
    .NARROW_W(BYTE_W),
    .NIB_BIT (4)
  ) u_calc (
    .opa_i (opa_i),
    .opb_i (opb_i),
    .res_i (alu_res_i),
    .co_i  (alu_co_i),
    .op_i  (op_cls),
    .wide_i(word_i),
    .cond_o(calc_cond),
    .upd_o (calc_upd)
  );

  always_comb begin
    wr_cond   = '0;
    wr_cond.c = wr_word_i[C_POS];
    wr_cond.p = wr_word_i[P_POS];
    wr_cond.a = wr_word_i[A_POS];
    wr_cond.z = wr_word_i[Z_POS];
    wr_cond.s = wr_word_i[S_POS];
    wr_cond.o = wr_word_i[O_POS];
  end

  psw_cond_reg u_cond (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_cond_i(wr_cond),
    .upd_i    (calc_upd),
    .calc_i   (calc_cond),
    .cond_o   (cond_q)
  );

  psw_ctrl_flags u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_tf_i  (wr_word_i[T_POS]),
    .wr_if_i  (wr_word_i[I_POS]),
    .wr_df_i  (wr_word_i[D_POS]),
    .take_i   (irq_take_i),
    .ret_i    (irq_ret_i),
    .pop_tf_i (pop_word_i[T_POS]),
    .pop_if_i (pop_word_i[I_POS]),
    .ie_set_i (ie_set_i),
    .ie_clr_i (ie_clr_i),
    .dir_set_i(dir_set_i),
    .dir_clr_i(dir_clr_i),
    .tf_o     (tf),
    .if_o     (ie),
    .df_o     (df)
  );

  always_comb begin
    psw_o        = '0;
    psw_o[C_POS] = cond_q.c;
    psw_o[P_POS] = cond_q.p;
    psw_o[A_POS] = cond_q.a;
    psw_o[Z_POS] = cond_q.z;
    psw_o[S_POS] = cond_q.s;
    psw_o[O_POS] = cond_q.o;
    psw_o[T_POS] = tf;
    psw_o[I_POS] = ie;
    psw_o[D_POS] = df;
  end

  logic unused_top;
  assign unused_top = ^{pop_word_i & ~PSW_W'((1 << T_POS) | (1 << I_POS)),
                        wr_word_i & ~IMPL_MASK};

  AST_UNUSED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((psw_o & ~IMPL_MASK) == '0)); // R1
  AST_LOAD_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (psw_o == ($past(wr_word_i) & IMPL_MASK))); // R11
  AST_LOGIC_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_cls_i == 2'd3 && !wr_en_i) |=> (!psw_o[C_POS] && !psw_o[O_POS] && !psw_o[A_POS])); // R4
endmodule

// File: tb/psw_unit_test.sv
`timescale 1ns/1ps
module psw_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] opa = '0, opb = '0, res = '0, pop = '0, wrw = '0;
  logic        co = 1'b0, word = 1'b0;
  logic [1:0]  op = '0;
  logic        ie_set = 0, ie_clr = 0, dir_set = 0, dir_clr = 0;
  logic        take = 0, ret = 0, wr_en = 0;
  logic [15:0] psw;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  psw_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .opa_i(opa), .opb_i(opb), .alu_res_i(res),
    .alu_co_i(co), .op_cls_i(op), .word_i(word), .ie_set_i(ie_set),
    .ie_clr_i(ie_clr), .dir_set_i(dir_set), .dir_clr_i(dir_clr),
    .irq_take_i(take), .irq_ret_i(ret), .pop_word_i(pop), .wr_en_i(wr_en),
    .wr_word_i(wrw), .psw_o(psw)
  );

  typedef struct packed {
    logic [15:0] a;
    logic [15:0] b;
    logic [15:0] r;
    logic        c;
    logic [1:0]  op;
    logic        w;
    logic [15:0] exp;
  } vec_t;

  // op: 1 add, 2 sub, 3 logic, 0 none; w: 1 word
  localparam vec_t VECS [10] = '{
    '{16'h007F, 16'h0001, 16'h0080, 1'b0, 2'd1, 1'b0, 16'h0890}, // R8 R6 R7 byte overflow
    '{16'h00FF, 16'h0001, 16'h0000, 1'b1, 2'd1, 1'b0, 16'h0055}, // R4 R5 R7 carry + zero
    '{16'h0000, 16'h0001, 16'hFFFF, 1'b1, 2'd2, 1'b1, 16'h0095}, // R4 R6 borrow word
    '{16'h8000, 16'h0001, 16'h7FFF, 1'b0, 2'd2, 1'b1, 16'h0814}, // R8 sub overflow
    '{16'hF0F0, 16'h0F0F, 16'h0000, 1'b1, 2'd3, 1'b1, 16'h0044}, // R4 logic clears carry
    '{16'hFFFF, 16'hFF80, 16'hFF80, 1'b1, 2'd3, 1'b0, 16'h0080}, // R7 byte sign, upper ignored
    '{16'h1234, 16'h1111, 16'h2345, 1'b0, 2'd1, 1'b1, 16'h0000}, // R5 odd parity
    '{16'h0080, 16'h0080, 16'h0100, 1'b1, 2'd1, 1'b0, 16'h0845}, // R7 zero over byte width
    '{16'h0005, 16'h0007, 16'h00FE, 1'b1, 2'd2, 1'b0, 16'h0091}, // R6 byte borrow
    '{16'h1111, 16'h2222, 16'h0000, 1'b0, 2'd0, 1'b1, 16'h0091}  // R3 class none holds
  };

  task automatic chk(input logic [15:0] exp, input string tag);
    total++;
    if (psw !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, psw, exp);
    end
  endtask

  task automatic idle();
    op = 2'd0; ie_set = 0; ie_clr = 0; dir_set = 0; dir_clr = 0;
    take = 0; ret = 0; wr_en = 0;
  endtask

  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    @(negedge clk);
    chk(16'h0000, "R2 reset word");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(16'h0000, "R2 after release");

    foreach (VECS[i]) begin
      opa = VECS[i].a; opb = VECS[i].b; res = VECS[i].r;
      co = VECS[i].c; op = VECS[i].op; word = VECS[i].w;
      step();
      chk(VECS[i].exp, $sformatf("R3/R4/R5/R6/R7/R8 vector %0d", i));
    end

    // full write of all ones: only implemented bits (R1, R11)
    wr_en = 1; wrw = 16'hFFFF; step();
    chk(16'h0FD5, "R1 unused bits zero");

    take = 1; step();
    chk(16'h0CD5, "R9 take clears trace and enable");

    ret = 1; pop = 16'h0100; step();
    chk(16'h0DD5, "R9 return restores from popped word");

    ie_set = 1; step();
    chk(16'h0FD5, "R10 enable set");

    ie_set = 1; ie_clr = 1; step();
    chk(16'h0DD5, "R10 enable clear wins");

    dir_clr = 1; dir_set = 1; step();
    chk(16'h09D5, "R10 direction clear wins");

    dir_set = 1; step();
    chk(16'h0DD5, "R10 direction set");

    ie_set = 1; take = 1; step();
    chk(16'h0CD5, "R10 take overrides enable set");

    ret = 1; take = 1; pop = 16'h0300; step();
    chk(16'h0FD5, "R9 return wins over take");

    // write wins over ALU update and commands
    wr_en = 1; wrw = 16'h0000; op = 2'd1; co = 1; word = 1; opa = 16'h0; opb = 16'h0;
    res = 16'h8000; ie_set = 1; take = 1; step();
    chk(16'h0000, "R11 write overrides all");

    wr_en = 1; wrw = 16'h0100; step();
    chk(16'h0100, "R11 trace via write");

    opa = 16'h00FF; opb = 16'h0001; res = 16'h0000; co = 1; op = 2'd1; word = 0;
    ie_clr = 1; dir_set = 1; step();
    chk(16'h0555, "R11 trace untouched by ALU and commands");

    step();
    chk(16'h0555, "R3 idle hold");

    rst_n = 1'b0;
    @(negedge clk);
    chk(16'h0000, "R2 async reset mid-run");

    done = 1;
    finish_run();
  end
endmodule